// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Controller

This block sits between the interrupt pins of an 8-bit processor and its core sequencer. It takes the asynchronous maskable request, the asynchronous non-maskable request and an asynchronous pin reset, and brings each into the clock domain through a synchronizer chain. It keeps the interrupt-enable flag, the selected maskable response mode and an 8-bit page register. When the core reports an instruction boundary, the block picks the request to serve and hands back a jump target with a one-cycle valid strobe.

The non-maskable request is edge-triggered and has a fixed target. A maskable request first runs an acknowledge cycle. In that cycle the processor marks an opcode fetch and an I/O request together, and the interrupting device places a byte on the data bus. What happens to that byte depends on the mode:
- In the opcode mode the byte is returned for the core to execute.
- In the fixed mode the byte is discarded and a constant target is returned.
- In the table mode the byte forms the low half of a pointer, and the page register forms the high half. The block then reads a 16-bit service address from that pointer over a request/acknowledge memory port.

Pushing the return address and executing instructions are left to the core.

Top module: `vec_irq_ack`

## Requirements
- R1: While `rst_ni` is low, and at the first clock after it rises, the ports read as follows: `ie_o`=0, `busy_o`=0, `m1_o`=0, `iorq_o`=0, `mem_req_o`=0 and `target_vld_o`=0. The mode and the page register reset to 0.
- R2: `int_ni`, `nmi_ni` and `pin_rst_ni` each pass through SYNC_STAGES flops (default 2) before any logic uses them. A `take_i` pulse sampled at the same edge where `int_ni` was first captured does not start a service.
- R3: While `ie_o` is 0, a low `int_ni` is ignored. `take_i` then leaves `busy_o`, `m1_o` and `target_vld_o` at 0.
- R4: Accepting either interrupt clears `ie_o`, and `ie_o` already reads 0 in the first busy cycle. Otherwise `ie_clr_i` clears the flag and `ie_set_i` sets it, with clear taking priority over set.
- R5: A falling edge on the synchronized `nmi_ni` latches a pending request. At `take_i` it wins over a maskable request. It returns target 0x0066 with `op_fetch_o`=0, runs no acknowledge cycle and clears the latch. Holding `nmi_ni` low does not raise a second request.
- R6: A maskable service runs exactly one cycle with `m1_o`=1 and `iorq_o`=0. It then runs ACK_LEN cycles (default 2) with both signals at 1. `data_i` is sampled only in the last of those cycles, and `iorq_o` is never 1 without `m1_o`.
- R7: In mode value 2, the pointer is {page, device byte}. The low target byte is read from the pointer and the high byte from pointer+1, with 16-bit wrap. The result is `target_o`={high, low} with `op_fetch_o`=0.
- R8: In mode value 1, the device byte is ignored and the result is `target_o`=0x0038 with `op_fetch_o`=0.
- R9: In mode value 0, the result is `target_o`={8'h00, device byte} with `op_fetch_o`=1.
- R10: `mode_wr_i` loads `mode_sel_i` when it is 0, 1 or 2. A write of value 3 leaves the mode unchanged.
- R11: `target_vld_o` is a one-cycle pulse, and `busy_o` is 0 in the cycle after it.
- R12: When the synchronized `pin_rst_ni` stays low for RST_HOLD consecutive cycles (default 3), the enable flag, mode, page register, pending non-maskable latch and sequencer all reset. A shorter low pulse changes nothing.
- R13: `mem_addr_o` holds steady while `mem_req_o` is 1 and `mem_ack_i` is 0. `mem_req_o` and `m1_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| pin_rst_ni | input | 1 | Asynchronous active-low pin reset, qualified by hold time |
| int_ni | input | 1 | Asynchronous active-low maskable request |
| nmi_ni | input | 1 | Asynchronous active-low non-maskable request, edge-triggered |
| take_i | input | 1 | Core is at an instruction boundary and can take an interrupt |
| ie_set_i | input | 1 | Set the interrupt-enable flag |
| ie_clr_i | input | 1 | Clear the interrupt-enable flag |
| mode_wr_i | input | 1 | Load the response mode |
| mode_sel_i | input | 2 | Mode value: 0 opcode, 1 fixed, 2 table |
| ireg_wr_i | input | 1 | Load the page register |
| ireg_d_i | input | 8 | Page register data |
| data_i | input | 8 | Data bus: device byte or memory read data |
| m1_o | output | 1 | Acknowledge-fetch marker |
| iorq_o | output | 1 | I/O request during acknowledge |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_ack_i | input | 1 | Memory read data valid on `data_i` |
| busy_o | output | 1 | Service sequence in progress |
| ie_o | output | 1 | Interrupt-enable flag |
| target_o | output | 16 | Jump target, or opcode in the low byte |
| target_vld_o | output | 1 | One-cycle strobe for `target_o` |
| op_fetch_o | output | 1 | `target_o[7:0]` is an opcode to execute |

## Verification
The assertions assume `take_i`, the register-write strobes and `mem_ack_i` are synchronous single-cycle signals. They also assume `mem_ack_i` is raised only while `mem_req_o` is high, and that `pin_rst_ni` is not asserted in the middle of a memory read. The stimulus changes every input only on the falling clock edge. The memory model answers only while a request is pending, after a latency of zero to two cycles, and the pin-reset tests run only while the sequencer is idle. The device byte is driven only while both acknowledge markers are high, and a different byte sits on the bus at all other times.

// File: rtl/vi_pkg.sv
package vi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACK_M1, ST_ACK_IO, ST_RD_LO, ST_RD_HI, ST_DONE
  } vi_state_e;

  typedef enum logic [1:0] {
    MD_OPCODE = 2'd0,
    MD_FIXED  = 2'd1,
    MD_TABLE  = 2'd2
  } vi_mode_e;

  localparam logic [15:0] VEC_NMI   = 16'h0066;
  localparam logic [15:0] VEC_FIXED = 16'h0038;
endpackage

// File: rtl/vi_sync.sv
module vi_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stg[0] <= RST_VAL;
    else         stg[0] <= d_i;

  for (genvar g = 1; g < STAGES; g++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) stg[g] <= RST_VAL;
      else         stg[g] <= stg[g-1];
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/vi_rstq.sv
// Turns a synchronized pin reset into an internal reset once held long enough.
module vi_rstq #(
  parameter int RST_HOLD = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_rst_s_ni,
  output logic soft_rst_o
);
  localparam int CW = $clog2(RST_HOLD + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (pin_rst_s_ni)  cnt_q <= '0;
    else if (cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;

  assign soft_rst_o = (cnt_q == LIM);
endmodule

// File: rtl/vi_ctl.sv
module vi_ctl
  import vi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       nmi_s_ni,
  input  logic       acc_nmi_i,
  input  logic       acc_int_i,
  input  logic       ie_set_i,
  input  logic       ie_clr_i,
  input  logic       mode_wr_i,
  input  logic [1:0] mode_sel_i,
  input  logic       ireg_wr_i,
  input  logic [7:0] ireg_d_i,
  output logic       ie_o,
  output vi_mode_e   mode_o,
  output logic [7:0] ireg_o,
  output logic       nmi_pend_o
);
  logic nmi_prev_q;
  logic nmi_fall;

  assign nmi_fall = nmi_prev_q & ~nmi_s_ni;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ie_o       <= 1'b0;
      mode_o     <= MD_OPCODE;
      ireg_o     <= '0;
      nmi_pend_o <= 1'b0;
      nmi_prev_q <= 1'b1;
    end else if (soft_rst_i) begin
      ie_o       <= 1'b0;
      mode_o     <= MD_OPCODE;
      ireg_o     <= '0;
      nmi_pend_o <= 1'b0;
      nmi_prev_q <= nmi_s_ni;  // no spurious edge after release
    end else begin
      nmi_prev_q <= nmi_s_ni;
      if (nmi_fall)       nmi_pend_o <= 1'b1;
      else if (acc_nmi_i) nmi_pend_o <= 1'b0;
      if (acc_nmi_i || acc_int_i || ie_clr_i) ie_o <= 1'b0;
      else if (ie_set_i)                      ie_o <= 1'b1;
      if (mode_wr_i && mode_sel_i != 2'd3) mode_o <= vi_mode_e'(mode_sel_i);
      if (ireg_wr_i) ireg_o <= ireg_d_i;
    end
endmodule

// File: rtl/vi_seq.sv
module vi_seq
  import vi_pkg::*;
#(
  parameter int ACK_LEN = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        soft_rst_i,
  input  logic        take_i,
  input  logic        nmi_pend_i,
  input  logic        int_ok_i,
  input  vi_mode_e    mode_i,
  input  logic [7:0]  ireg_i,
  input  logic [7:0]  data_i,
  input  logic        mem_ack_i,
  output logic        acc_nmi_o,
  output logic        acc_int_o,
  output logic        m1_o,
  output logic        iorq_o,
  output logic        mem_req_o,
  output logic [15:0] mem_addr_o,
  output logic        busy_o,
  output logic [15:0] target_o,
  output logic        target_vld_o,
  output logic        op_fetch_o
);
  localparam int CW = (ACK_LEN > 1) ? $clog2(ACK_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACK_LEN - 1);

  vi_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [15:0]   ptr_q;
  logic [7:0]    lo_q;

  assign acc_nmi_o = (st_q == ST_IDLE) && take_i && nmi_pend_i;
  assign acc_int_o = (st_q == ST_IDLE) && take_i && !nmi_pend_i && int_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      ptr_q      <= '0;
      lo_q       <= '0;
      target_o   <= '0;
      op_fetch_o <= 1'b0;
    end else if (soft_rst_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (acc_nmi_o) begin
            target_o   <= VEC_NMI;
            op_fetch_o <= 1'b0;
            st_q       <= ST_DONE;
          end else if (acc_int_o) begin
            st_q <= ST_ACK_M1;
          end
        end
        ST_ACK_M1: begin
          cnt_q <= '0;
          st_q  <= ST_ACK_IO;
        end
        ST_ACK_IO: begin
          if (cnt_q == LAST) begin
            ptr_q <= {ireg_i, data_i};
            unique case (mode_i)
              MD_TABLE: st_q <= ST_RD_LO;
              MD_FIXED: begin
                target_o   <= VEC_FIXED;
                op_fetch_o <= 1'b0;
                st_q       <= ST_DONE;
              end
              default: begin
                target_o   <= {8'h00, data_i};
                op_fetch_o <= 1'b1;
                st_q       <= ST_DONE;
              end
            endcase
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RD_LO: if (mem_ack_i) begin
          lo_q <= data_i;
          st_q <= ST_RD_HI;
        end
        ST_RD_HI: if (mem_ack_i) begin
          target_o   <= {data_i, lo_q};
          op_fetch_o <= 1'b0;
          st_q       <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end

  assign m1_o         = (st_q == ST_ACK_M1) || (st_q == ST_ACK_IO);
  assign iorq_o       = (st_q == ST_ACK_IO);
  assign mem_req_o    = (st_q == ST_RD_LO) || (st_q == ST_RD_HI);
  assign mem_addr_o   = (st_q == ST_RD_HI) ? ptr_q + 16'd1 : ptr_q;
  assign busy_o       = (st_q != ST_IDLE);
  assign target_vld_o = (st_q == ST_DONE);
endmodule

// File: rtl/vec_irq_ack.sv
module vec_irq_ack
  import vi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACK_LEN     = 2,
  parameter int RST_HOLD    = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pin_rst_ni,
  input  logic        int_ni,
  input  logic        nmi_ni,
  input  logic        take_i,
  input  logic        ie_set_i,
  input  logic        ie_clr_i,
  input  logic        mode_wr_i,
  input  logic [1:0]  mode_sel_i,
  input  logic        ireg_wr_i,
  input  logic [7:0]  ireg_d_i,
  input  logic [7:0]  data_i,
  output logic        m1_o,
  output logic        iorq_o,
  output logic        mem_req_o,
  output logic [15:0] mem_addr_o,
  input  logic        mem_ack_i,
  output logic        busy_o,
  output logic        ie_o,
  output logic [15:0] target_o,
  output logic        target_vld_o,
  output logic        op_fetch_o
);
  logic [2:0] pins_s;
  logic       soft_rst, acc_nmi, acc_int, nmi_pend;
  vi_mode_e   mode;
  logic [7:0] ireg;

  vi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pin_rst_ni, nmi_ni, int_ni}),
    .q_o   (pins_s)
  );

  vi_rstq #(.RST_HOLD(RST_HOLD)) u_rstq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_rst_s_ni(pins_s[2]),
    .soft_rst_o  (soft_rst)
  );

  vi_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst),
    .nmi_s_ni  (pins_s[1]),
    .acc_nmi_i (acc_nmi),
    .acc_int_i (acc_int),
    .ie_set_i  (ie_set_i),
    .ie_clr_i  (ie_clr_i),
    .mode_wr_i (mode_wr_i),
    .mode_sel_i(mode_sel_i),
    .ireg_wr_i (ireg_wr_i),
    .ireg_d_i  (ireg_d_i),
    .ie_o      (ie_o),
    .mode_o    (mode),
    .ireg_o    (ireg),
    .nmi_pend_o(nmi_pend)
  );

  vi_seq #(.ACK_LEN(ACK_LEN)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst),
    .take_i      (take_i),
    .nmi_pend_i  (nmi_pend),
    .int_ok_i    (!pins_s[0] && ie_o),
    .mode_i      (mode),
    .ireg_i      (ireg),
    .data_i      (data_i),
    .mem_ack_i   (mem_ack_i),
    .acc_nmi_o   (acc_nmi),
    .acc_int_o   (acc_int),
    .m1_o        (m1_o),
    .iorq_o      (iorq_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .busy_o      (busy_o),
    .target_o    (target_o),
    .target_vld_o(target_vld_o),
    .op_fetch_o  (op_fetch_o)
  );
endmodule

// File: rtl/vi_chk.sv
module vi_chk #(
  parameter int ACK_LEN = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        m1_o,
  input logic        iorq_o,
  input logic        mem_req_o,
  input logic        mem_ack_i,
  input logic [15:0] mem_addr_o,
  input logic        busy_o,
  input logic        ie_o,
  input logic        target_vld_o
);
  logic [7:0] io_run_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     io_run_q <= '0;
    else if (iorq_o) io_run_q <= io_run_q + 8'd1;
    else             io_run_q <= '0;

  assert_iorq_in_m1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iorq_o |-> m1_o);

  assert_iorq_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iorq_o |-> (int'(io_run_q) < ACK_LEN));

  assert_mem_not_m1_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !m1_o);

  assert_addr_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (!mem_req_o || $stable(mem_addr_o)));

  assert_vld_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_vld_o |=> (!target_vld_o && !busy_o));

  assert_ie_clr_on_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(busy_o)) |-> !ie_o);
endmodule

bind vec_irq_ack vi_chk #(.ACK_LEN(ACK_LEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .m1_o        (m1_o),
  .iorq_o      (iorq_o),
  .mem_req_o   (mem_req_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o),
  .busy_o      (busy_o),
  .ie_o        (ie_o),
  .target_vld_o(target_vld_o)
);

// File: tb/tb_vec_irq_ack.sv
module tb_vec_irq_ack;
  localparam int ACK_LEN = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_rst_ni = 1'b1, int_ni = 1'b1, nmi_ni = 1'b1;
  logic        take_i = 1'b0, ie_set_i = 1'b0, ie_clr_i = 1'b0;
  logic        mode_wr_i = 1'b0, ireg_wr_i = 1'b0;
  logic [1:0]  mode_sel_i = '0;
  logic [7:0]  ireg_d_i = '0, data_i = '0;
  logic        mem_ack_i = 1'b0;
  logic        m1_o, iorq_o, mem_req_o, busy_o, ie_o, target_vld_o, op_fetch_o;
  logic [15:0] mem_addr_o, target_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] dev_byte = 8'h00;
  int mem_lat = 0;
  int lat_cnt = 0;

  always #2 clk_i = ~clk_i;

  vec_irq_ack #(.ACK_LEN(ACK_LEN)) dut (.*);

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // device and memory model, driven on falling edges
  initial begin
    forever begin
      @(negedge clk_i);
      if (m1_o && iorq_o) begin
        mem_ack_i = 1'b0; data_i = dev_byte; lat_cnt = 0;
      end else if (mem_req_o) begin
        if (lat_cnt >= mem_lat) begin
          mem_ack_i = 1'b1; data_i = memf(mem_addr_o); lat_cnt = 0;
        end else begin
          mem_ack_i = 1'b0; data_i = ~dev_byte; lat_cnt++;
        end
      end else begin
        mem_ack_i = 1'b0; data_i = ~dev_byte; lat_cnt = 0;
      end
    end
  end

  task automatic pulse_ie_set();
    @(negedge clk_i) ie_set_i = 1'b1; @(negedge clk_i) ie_set_i = 1'b0;
  endtask

  task automatic wr_mode(input logic [1:0] m);
    @(negedge clk_i) begin mode_wr_i = 1'b1; mode_sel_i = m; end
    @(negedge clk_i) mode_wr_i = 1'b0;
  endtask

  task automatic wr_ireg(input logic [7:0] v);
    @(negedge clk_i) begin ireg_wr_i = 1'b1; ireg_d_i = v; end
    @(negedge clk_i) ireg_wr_i = 1'b0;
  endtask

  task automatic take(output logic got, output logic [15:0] t, output logic op,
                      output int io_n, output int m1_n);
    got = 1'b0; t = '0; op = 1'b0; io_n = 0; m1_n = 0;
    @(negedge clk_i) take_i = 1'b1;
    @(negedge clk_i) take_i = 1'b0;
    for (int k = 0; k < 60; k++) begin
      if (target_vld_o) begin
        got = 1'b1; t = target_o; op = op_fetch_o; break;
      end
      if (m1_o && iorq_o) io_n++;
      if (m1_o && !iorq_o) m1_n++;
      @(negedge clk_i);
    end
  endtask

  task automatic expect_none(input string req);
    logic seen = 1'b0;
    @(negedge clk_i) take_i = 1'b1;
    @(negedge clk_i) take_i = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (busy_o || m1_o || target_vld_o) seen = 1'b1;
      @(negedge clk_i);
    end
    chk(req, {31'd0, seen}, 32'd0);
  endtask

  task automatic run_int(input string req, input logic [1:0] md, input logic [7:0] iv,
                         input logic [7:0] db, input int lat,
                         input logic [15:0] exp_t, input logic exp_op);
    logic got, op; logic [15:0] t; int io_n, m1_n;
    wr_mode(md);
    wr_ireg(iv);
    pulse_ie_set();
    dev_byte = db; mem_lat = lat;
    @(negedge clk_i) int_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    take(got, t, op, io_n, m1_n);
    chk({req, " strobe"}, {31'd0, got}, 32'd1);
    chk({req, " target"}, {16'd0, t}, {16'd0, exp_t});
    chk({req, " op_fetch R9"}, {31'd0, op}, {31'd0, exp_op});
    chk("R6 iorq cycles", io_n, ACK_LEN);
    chk("R6 m1-only cycles", m1_n, 1);
    chk("R4 ie cleared", {31'd0, ie_o}, 32'd0);
    @(negedge clk_i);
    chk("R11 idle after strobe", {30'd0, busy_o, target_vld_o}, 32'd0);
    int_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    logic got, op; logic [15:0] t; int io_n, m1_n;
    logic [7:0] ivs [5] = '{8'h00, 8'h12, 8'h7F, 8'hA5, 8'hFF};
    logic [7:0] dbs [5] = '{8'h00, 8'h01, 8'h80, 8'hFE, 8'hFF};
    repeat (3) @(negedge clk_i);
    chk("R1 reset outputs", {26'd0, ie_o, busy_o, m1_o, iorq_o, mem_req_o, target_vld_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", {26'd0, ie_o, busy_o, m1_o, iorq_o, mem_req_o, target_vld_o}, 32'd0);

    // R3: disabled flag blocks maskable
    int_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    expect_none("R3 ignored while disabled");
    int_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R2: take at the edge that first captures int_ni is not served
    wr_mode(2'd1);
    pulse_ie_set();
    @(negedge clk_i) begin int_ni = 1'b0; take_i = 1'b1; end
    @(negedge clk_i) take_i = 1'b0;
    chk("R2 unsynced take ignored", {31'd0, busy_o}, 32'd0);
    int_ni = 1'b1;
    pulse_ie_set();
    repeat (4) @(negedge clk_i);
    chk("R4 ie set", {31'd0, ie_o}, 32'd1);
    @(negedge clk_i) ie_clr_i = 1'b1;
    @(negedge clk_i) ie_clr_i = 1'b0;
    chk("R4 ie clear", {31'd0, ie_o}, 32'd0);

    // R7: table mode sweep
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++) begin
        logic [15:0] p;
        p = {ivs[i], dbs[j]};
        run_int("R7 table", 2'd2, ivs[i], dbs[j], (i + j) % 3,
                {memf(p + 16'd1), memf(p)}, 1'b0);
      end

    // R8 fixed mode, byte ignored
    for (int j = 0; j < 5; j++)
      run_int("R8 fixed", 2'd1, 8'h40, dbs[j], 0, 16'h0038, 1'b0);
    // R10: value 3 leaves mode at fixed
    run_int("R10 mode 3 ignored", 2'd3, 8'h40, 8'h5A, 0, 16'h0038, 1'b0);
    // R9 opcode mode
    for (int j = 0; j < 5; j++)
      run_int("R9 opcode", 2'd0, 8'h40, dbs[j], 0, {8'h00, dbs[j]}, 1'b1);

    // R5: NMI wins, no ack cycle, no retrigger while held
    wr_mode(2'd1);
    pulse_ie_set();
    @(negedge clk_i) begin int_ni = 1'b0; nmi_ni = 1'b0; end
    repeat (4) @(negedge clk_i);
    take(got, t, op, io_n, m1_n);
    chk("R5 nmi target", {16'd0, t}, 32'h0066);
    chk("R5 nmi no ack", io_n + m1_n, 0);
    chk("R5 nmi clears ie R4", {31'd0, ie_o}, 32'd0);
    repeat (2) @(negedge clk_i);
    pulse_ie_set();
    take(got, t, op, io_n, m1_n);
    chk("R5 held nmi no retrigger", {16'd0, t}, 32'h0038);
    @(negedge clk_i) begin int_ni = 1'b1; nmi_ni = 1'b1; end
    repeat (4) @(negedge clk_i);

    // R12: short pin reset ignored
    pulse_ie_set();
    @(negedge clk_i) pin_rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i) pin_rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    chk("R12 short pulse ignored", {31'd0, ie_o}, 32'd1);
    // R12: long pin reset clears ie, mode and pending nmi
    wr_mode(2'd2);
    @(negedge clk_i) nmi_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    pin_rst_ni = 1'b0;
    repeat (8) @(negedge clk_i);
    pin_rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    chk("R12 ie reset", {31'd0, ie_o}, 32'd0);
    expect_none("R12 nmi latch cleared");
    nmi_ni = 1'b1;
    pulse_ie_set();
    dev_byte = 8'hC7;
    @(negedge clk_i) int_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    take(got, t, op, io_n, m1_n);
    chk("R12 mode back to opcode", {15'd0, op, t}, {15'd0, 1'b1, 16'h00C7});
    int_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule